// File: doc/BRIEF.md
# Four-Drive Floppy Select and Identification Controller

This block decodes a single active-low control byte shared by four floppy drives. Each write carries a motor request, one select line per drive, a head-side choice, a step direction and a step strobe. Motor state is not driven straight from the byte. Each drive captures the motor request only at the moment its own select line changes to active, so different drives can hold different motor states while sharing one wire.

Each drive also owns a serial identification shift register. The register moves left by one place every time that drive is deselected. It is reloaded with all ones when the drive is selected while its latched motor goes from on to off. Software reads the register one bit at a time through the ready position of an active-low status byte. That byte also reports track-zero, write-protect and not-ready for the lowest-numbered selected drive. The per-drive status inputs pass through a synchroniser before use.

Step strobes are one-cycle pulses. A drive receives a pulse only when the step bit rises between two writes and the drive is selected in the newer write.

Top module: `fsel_ctrl`

## Requirements
- R1: After reset the held control byte is 0xFF: no drive is selected, every motor output is 0, every step output is 0, and the status byte reads 0xFF. Every identification register holds all ones.
- R2: A drive's motor output changes only on a write that moves that drive's select line (control bit 3+d for drive d, active low) from 1 to 0. It then takes the inverse of control bit 7. Every other write leaves it unchanged.
- R3: On a write that selects drive d while its motor output is 1 and control bit 7 is 1, the identification register of drive d is reloaded with all ones.
- R4: On a write that moves drive d's select line from 0 to 1, its identification register shifts left by one and a 0 enters at bit 0.
- R5: step_o[d] is 1 for exactly the one cycle after a write in which control bit 0 rises from 0 to 1 relative to the previous write and select bit 3+d of the new byte is 0. In every other cycle it is 0.
- R6: side_o is 1 when bit 2 of the last written byte is 0. dir_o equals bit 1 of the last written byte, where 1 means outward. Both apply to all drives.
- R7: Status bit 5 is 0 exactly when bit 15 of the OR of the identification registers of all selected drives is 1, or when the lowest-numbered selected drive has its motor output at 1.
- R8: Status bits 4, 3 and 2 are the inverses of the lowest-numbered selected drive's synchronised track-zero, write-protect and not-ready, in that order. With no drive selected these bits are 1. Bits 7, 6, 1 and 0 are always 1.
- R9: A change on trk0_i, wp_i or rdy_i first appears in status_o after the second rising clock edge following it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the control byte |
| wr_data_i | input | 8 | Control byte: motor_n, sel_n[3:0], side_n, dir, step_n |
| trk0_i | input | 4 | Per-drive head at track zero, active high, asynchronous |
| wp_i | input | 4 | Per-drive write protected, active high, asynchronous |
| rdy_i | input | 4 | Per-drive ready, active high, asynchronous |
| motor_o | output | 4 | Per-drive latched motor on |
| step_o | output | 4 | Per-drive one-cycle step pulse |
| side_o | output | 1 | Head side 1 selected |
| dir_o | output | 1 | Step direction, 1 = outward |
| status_o | output | 8 | Active-low status byte |

## Verification
A single write can deselect one drive, select another and raise the step bit. In that one write the first drive's identification register shifts, the second drive latches its motor (and may reload its register), and a step pulse is issued to the newly selected drive. Random control bytes from a fixed seed produce all of these combinations, including simultaneous shift, reload, latch and step, on many writes. Directed sequences add a long run of deselects that walks bit 15 out of the register, and a reload on a motor on-to-off change. After every write, a bench model of the motor latches, identification registers and step rule is compared against the outputs and the status byte.

// File: rtl/fsel_pkg.sv
package fsel_pkg;
  localparam int NUM_DRV = 4;

  typedef struct packed {
    logic       motor_n;
    logic [3:0] sel_n;
    logic       side_n;
    logic       dir;
    logic       step_n;
  } ctrl_t;
endpackage

// File: rtl/fsel_sync.sv
module fsel_sync #(
  parameter int W      = 12,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/fsel_drive_slot.sv
module fsel_drive_slot #(
  parameter int              ID_W      = 32,
  parameter logic [ID_W-1:0] ID_RELOAD = '1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic            sel_old_n_i,
  input  logic            sel_new_n_i,
  input  logic            motor_new_i,
  input  logic            step_rise_i,
  output logic            motor_o,
  output logic [ID_W-1:0] id_o,
  output logic            step_o
);
  logic            motor_q;
  logic [ID_W-1:0] id_q;
  logic            step_q;
  logic            sel_edge;

  assign sel_edge = wr_i & (sel_old_n_i ^ sel_new_n_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      motor_q <= 1'b0;
      id_q    <= ID_RELOAD;
      step_q  <= 1'b0;
    end else begin
      step_q <= wr_i & step_rise_i & ~sel_new_n_i;
      if (sel_edge) begin
        if (sel_new_n_i) begin
          id_q <= {id_q[ID_W-2:0], 1'b0};
        end else begin
          if (motor_q && !motor_new_i) id_q <= ID_RELOAD;
          motor_q <= motor_new_i;
        end
      end
    end
  end

  assign motor_o = motor_q;
  assign id_o    = id_q;
  assign step_o  = step_q;

  AST_MOTOR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_edge |=> $stable(motor_q)); // R2
  AST_ID_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_edge && !sel_new_n_i && motor_q && !motor_new_i) |=> id_q == ID_RELOAD); // R3
  AST_ID_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_edge && sel_new_n_i) |=> id_q == {$past(id_q[ID_W-2:0]), 1'b0}); // R4
  AST_STEP_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_q |-> $past(wr_i && !sel_new_n_i && step_rise_i)); // R5
  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_q |=> !step_q); // R5
endmodule

// File: rtl/fsel_status.sv
module fsel_status #(
  parameter int N      = 4,
  parameter int ID_W   = 32,
  parameter int ID_TAP = 15
) (
  input  logic [N-1:0]           sel_n_i,
  input  logic [N-1:0]           motor_i,
  input  logic [N-1:0][ID_W-1:0] id_i,
  input  logic [N-1:0]           trk0_i,
  input  logic [N-1:0]           wp_i,
  input  logic [N-1:0]           rdy_i,
  output logic [7:0]             status_o
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic [ID_W-1:0]  id_or;
  logic [IDX_W-1:0] idx;
  logic             hit;
  logic [7:0]       act;

  always_comb begin
    id_or = '0;
    idx   = '0;
    hit   = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!sel_n_i[i]) begin
        id_or = id_or | id_i[i];
        idx   = IDX_W'(i);  // lowest index wins
        hit   = 1'b1;
      end
    end
    act    = '0;
    act[5] = id_or[ID_TAP] | (hit & motor_i[idx]);
    act[4] = hit & trk0_i[idx];
    act[3] = hit & wp_i[idx];
    act[2] = hit & ~rdy_i[idx];
    status_o = ~act;
  end

  always_comb begin
    AST_PAD_HIGH: assert ({status_o[7:6], status_o[1:0]} == 4'hF); // R8
  end
endmodule

// File: rtl/fsel_ctrl.sv
module fsel_ctrl
  import fsel_pkg::*;
#(
  parameter int              ID_W        = 32,
  parameter int              ID_TAP      = 15,
  parameter int              SYNC_STAGES = 2,
  parameter logic [ID_W-1:0] ID_RELOAD   = '1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [7:0]         wr_data_i,
  input  logic [NUM_DRV-1:0] trk0_i,
  input  logic [NUM_DRV-1:0] wp_i,
  input  logic [NUM_DRV-1:0] rdy_i,
  output logic [NUM_DRV-1:0] motor_o,
  output logic [NUM_DRV-1:0] step_o,
  output logic               side_o,
  output logic               dir_o,
  output logic [7:0]         status_o
);
  localparam int SYNC_W = 3 * NUM_DRV;

  ctrl_t ctrl_q, ctrl_new;
  logic  step_rise;
  logic [NUM_DRV-1:0][ID_W-1:0] id_w;
  logic [SYNC_W-1:0] sync_w;

  assign ctrl_new  = ctrl_t'(wr_data_i);
  assign step_rise = ~ctrl_q.step_n & ctrl_new.step_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= ctrl_t'(8'hFF);
    else if (wr_en_i) ctrl_q <= ctrl_new;
  end

  fsel_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({rdy_i, wp_i, trk0_i}),
    .q_o    (sync_w)
  );

  for (genvar d = 0; d < NUM_DRV; d++) begin : g_drv
    fsel_drive_slot #(.ID_W(ID_W), .ID_RELOAD(ID_RELOAD)) u_slot (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_i        (wr_en_i),
      .sel_old_n_i (ctrl_q.sel_n[d]),
      .sel_new_n_i (ctrl_new.sel_n[d]),
      .motor_new_i (~ctrl_new.motor_n),
      .step_rise_i (step_rise),
      .motor_o     (motor_o[d]),
      .id_o        (id_w[d]),
      .step_o      (step_o[d])
    );
  end

  fsel_status #(.N(NUM_DRV), .ID_W(ID_W), .ID_TAP(ID_TAP)) u_status (
    .sel_n_i  (ctrl_q.sel_n),
    .motor_i  (motor_o),
    .id_i     (id_w),
    .trk0_i   (sync_w[NUM_DRV-1:0]),
    .wp_i     (sync_w[2*NUM_DRV-1:NUM_DRV]),
    .rdy_i    (sync_w[3*NUM_DRV-1:2*NUM_DRV]),
    .status_o (status_o)
  );

  assign side_o = ~ctrl_q.side_n;
  assign dir_o  = ctrl_q.dir;

  AST_SIDE_DIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (side_o == ~$past(wr_data_i[2])) && (dir_o == $past(wr_data_i[1]))); // R6
endmodule

// File: tb/fsel_ctrl_tb.sv
module fsel_ctrl_tb;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'hFF;
  logic [3:0] trk0 = 4'h0, wp = 4'h0, rdy = 4'hF;
  logic [3:0] motor, step;
  logic       side, dir;
  logic [7:0] status;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [7:0]  pm;
  logic [3:0]  mm;
  logic [31:0] im [4];

  always #(CLK_P/2) clk = ~clk;

  fsel_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .trk0_i(trk0), .wp_i(wp), .rdy_i(rdy),
    .motor_o(motor), .step_o(step), .side_o(side), .dir_o(dir),
    .status_o(status)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_status();
    logic [31:0] id_or = '0;
    logic [7:0]  a = '0;
    int s = -1;
    for (int c = 3; c >= 0; c--)
      if (!pm[3+c]) begin id_or |= im[c]; s = c; end
    a[5] = id_or[15] | (s >= 0 && mm[s]);
    if (s >= 0) begin
      a[4] = trk0[s];
      a[3] = wp[s];
      a[2] = ~rdy[s];
    end
    return ~a;
  endfunction

  task automatic do_write(input logic [7:0] v);
    logic [3:0] st_exp;
    for (int c = 0; c < 4; c++) begin
      st_exp[c] = !pm[0] && v[0] && !v[3+c];
      if (pm[3+c] != v[3+c]) begin
        if (v[3+c]) im[c] = im[c] << 1;
        else begin
          if (mm[c] && v[7]) im[c] = '1;
          mm[c] = !v[7];
        end
      end
    end
    pm = v;
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
    chk("R5 step", {28'h0, step}, {28'h0, st_exp});
    chk("R2 motor", {28'h0, motor}, {28'h0, mm});
    chk("R6 side/dir", {30'h0, side, dir}, {30'h0, ~v[2], v[1]});
    chk("R7 R8 R3 R4 status", {24'h0, status}, {24'h0, exp_status()});
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20231));
    pm = 8'hFF; mm = '0;
    for (int c = 0; c < 4; c++) im[c] = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 status", {24'h0, status}, 32'hFF);
    chk("R1 motor", {28'h0, motor}, 32'h0);
    chk("R1 step", {28'h0, step}, 32'h0);

    // select drive 0 motor on: status bit5 low from ID bit 15 and motor
    do_write(8'h77);
    chk("R7 direct", {24'h0, status}, 32'hDF);
    do_write(8'h7E);  // deselect, step low
    do_write(8'h77);  // reselect with step rise: pulse only to drive 0
    // R3 reload: deselect with motor on, reselect with motor off
    do_write(8'hFF);
    do_write(8'hF7);
    chk("R3 reload motor off", {28'h0, motor}, 32'h0);
    // R4 walk bit 15 out of drive 0 register
    for (int k = 0; k < 17; k++) begin
      do_write(8'hFF);
      do_write(8'hF7);
    end
    chk("R4 bit15 shifted out", {24'h0, status}, 32'hFF);

    // R9 synchroniser latency with drive 0 selected
    @(negedge clk); trk0 = 4'b0001;
    @(negedge clk);
    chk("R9 after one edge", {31'h0, status[4]}, 32'h1);
    @(negedge clk);
    chk("R9 after two edges", {31'h0, status[4]}, 32'h0);
    chk("R8 track zero", {24'h0, status}, {24'h0, exp_status()});

    // random mix
    for (int n = 0; n < 600; n++) begin
      if (n % 25 == 0) begin
        @(negedge clk);
        trk0 = 4'($urandom); wp = 4'($urandom); rdy = 4'($urandom);
        repeat (3) @(negedge clk);
        chk("R8 settled status", {24'h0, status}, {24'h0, exp_status()});
      end
      do_write(8'($urandom));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule